// File: doc/BRIEF.md
# Scatter/Gather Descriptor Chain Walker

This block runs one independent chain walker for each DMA channel. Software puts a byte address into a channel's descriptor-address register. It then sets that channel's run bit in a shared command register. The walker then reads one descriptor from memory as five consecutive 32-bit words, in this order: control, source, destination, count word, next pointer. It copies the control word into the channel's visible control register. It then hands the source address, the destination address and a byte count to an external data mover and waits for that mover's done pulse. After the transfer it either follows the next pointer or finishes the chain.

Interrupts are set per descriptor. The count word carries a link flag, two completion-interrupt flags (one for a transfer that ran to its terminal count, one for a transfer the peripheral ended early), an error-interrupt flag and burst settings that the block carries but does not act on. A master interrupt-enable bit in the control word gates all of these flags. A run bit changes only when its mask bit is written in the same access. After a halt, an error or a normal finish, software reads back the descriptor address and remaining unit count to compute the residue.

Top module: `sgd_walker`

## Requirements
- R1: After reset every channel register and the command register read zero, and mem_req, xfer_start and irq are low.
- R2: A write to the command register (address 0x40) changes run bit c (bit c) only when mask bit 16+c is also set in that write. A read returns the run bits in bits [NCH-1:0] and zero elsewhere.
- R3: When its run bit is set, an idle channel fetches five 32-bit words from byte addresses D, D+4, D+8, D+12, D+16 (D = descriptor address), taking them as control, source, destination, count word and next pointer.
- R4: For each descriptor, the fetched control word is loaded into the channel control register (offset 0) before the transfer starts.
- R5: xfer_start pulses for exactly one cycle with the source, the destination and a byte count equal to the unit count (count word bits [CNT_W-1:0]) shifted left by control bits [1:0] (0: 8-bit, 1: 16-bit, 2: 32-bit, 3: 64-bit units). The channel then waits for xfer_done.
- R6: When count-word bit 31 (link) is set, a good transfer moves the descriptor-address register to the next pointer and fetches again. When bit 31 is clear, the chain ends and the run bit clears.
- R7: A good transfer sets the done-pending status only when control bit 31 is set and either (done without xfer_eot) count bit 30 is set or (done with xfer_eot) count bit 29 is set. Descriptors whose flags are clear raise nothing.
- R8: A done with xfer_err aborts the chain. It sets the fault status and clears the run bit. It sets error-pending when control bit 31 and count bit 28 are set. The descriptor-address and count registers keep the failing descriptor and its unit count.
- R9: mem_err on a fetched word aborts the chain with fault status, clears the run bit and raises no interrupt.
- R10: The status register (offset 3) holds done-pending in bit 0, error-pending in bit 1, fault in bit 2 and busy in bit 3. Writing 1 clears bits 0 to 2. irq is done-pending OR error-pending.
- R11: Clearing the run bit while busy returns the channel to idle within one cycle and issues no further transfer. The descriptor-address and count registers keep their values.
- R12: The descriptor-address register (offset 1) takes writes only while the channel is idle. Writes made while it is busy are ignored.
- R13: The count register (offset 2) returns the current count word with bits [CNT_W-1:0] replaced by the remaining units, which become zero after a good transfer.
- R14: Channel c's registers sit at addresses 8c+offset. Channels run independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | NCH | Descriptor word read request per channel |
| mem_addr | output | 32*NCH | Byte address of the requested word |
| mem_ack | input | NCH | Read data valid |
| mem_rdata | input | 32*NCH | Read data |
| mem_err | input | NCH | Read failed, qualified by mem_ack |
| xfer_start | output | NCH | One-cycle transfer start strobe |
| xfer_src | output | 32*NCH | Transfer source address |
| xfer_dst | output | 32*NCH | Transfer destination address |
| xfer_bytes | output | (CNT_W+3)*NCH | Transfer length in bytes |
| xfer_done | input | NCH | Transfer finished pulse |
| xfer_eot | input | NCH | Qualifies done: ended by the peripheral |
| xfer_err | input | NCH | Qualifies done: transfer failed |
| irq | output | NCH | Channel interrupt |

## Verification
The bench builds the block with NCH = 2 and CNT_W = 16. Two channels are enough to show that a masked command write to one channel leaves the other untouched. The 16-bit count keeps every byte count inside 19 bits. The bench runs every width code against chains of one, two and three descriptors. For each run it computes the fetch addresses, byte counts and final register contents arithmetically. Single-descriptor runs then cover each completion-flag, early-end and error case. Further runs cover a transfer error in the middle of a chain, a fetch error, and a halt during a transfer.

// File: rtl/sgd_pkg.sv
package sgd_pkg;

  localparam int CMD_MASK_LSB = 16;
  localparam int CTL_IE  = 31;
  localparam int CW_LINK = 31;
  localparam int CW_TCI  = 30;
  localparam int CW_EOTI = 29;
  localparam int CW_ERRI = 28;

  localparam logic [6:0] CMD_ADDR = 7'h40;
  localparam logic [2:0] OFF_CTRL = 3'd0;
  localparam logic [2:0] OFF_DESC = 3'd1;
  localparam logic [2:0] OFF_CNT  = 3'd2;
  localparam logic [2:0] OFF_STAT = 3'd3;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_FETCH  = 2'd1,
    S_XSTART = 2'd2,
    S_XWAIT  = 2'd3
  } walk_state_t;

  typedef enum logic [2:0] {
    F_CTRL = 3'd0,
    F_SRC  = 3'd1,
    F_DST  = 3'd2,
    F_CNT  = 3'd3,
    F_NEXT = 3'd4
  } fetch_idx_t;

  // Units are 1, 2, 4 or 8 bytes wide; wcode is log2 of the byte width.
  function automatic logic [31:0] units_to_bytes(input logic [31:0] units,
                                                 input logic [1:0]  wcode);
    return units << wcode;
  endfunction

  function automatic logic [31:0] field_addr(input logic [31:0] base,
                                             input fetch_idx_t  k);
    return base + {27'b0, k, 2'b00};
  endfunction

  function automatic logic cmpl_armed(input logic [31:0] ctrl,
                                      input logic [31:0] cw,
                                      input logic        eot);
    return ctrl[CTL_IE] && (eot ? cw[CW_EOTI] : cw[CW_TCI]);
  endfunction

  function automatic logic err_armed(input logic [31:0] ctrl,
                                     input logic [31:0] cw);
    return ctrl[CTL_IE] && cw[CW_ERRI];
  endfunction

endpackage

// File: rtl/sgd_cmd.sv
module sgd_cmd
  import sgd_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [NCH-1:0] wr_run,
  input  logic [NCH-1:0] wr_mask,
  input  logic [NCH-1:0] finish,
  output logic [NCH-1:0] run
);

  logic [NCH-1:0] run_q;

  for (genvar c = 0; c < NCH; c++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     run_q[c] <= 1'b0;
      else if (finish[c])             run_q[c] <= 1'b0;
      else if (we && wr_mask[c])      run_q[c] <= wr_run[c];
    end

    // R2: a run bit moves only through a masked write or a chain finish
    p_masked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(run_q[c]) |-> ($past(we && wr_mask[c]) || $past(finish[c])));
  end

  assign run = run_q;

endmodule

// File: rtl/sgd_chan.sv
module sgd_chan
  import sgd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we_desc,
  input  logic              we_stat,
  input  logic [31:0]       wdata,
  output logic [31:0]       ctrl_o,
  output logic [31:0]       desc_o,
  output logic [31:0]       cnt_o,
  output logic [31:0]       stat_o,
  output logic              finish,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_err,
  output logic              xfer_start,
  output logic [31:0]       xfer_src,
  output logic [31:0]       xfer_dst,
  output logic [CNT_W+2:0]  xfer_bytes,
  input  logic              xfer_done,
  input  logic              xfer_eot,
  input  logic              xfer_err,
  output logic              irq
);

  localparam int BW = CNT_W + 3;

  walk_state_t      state_q;
  fetch_idx_t       idx_q;
  logic [31:0]      desc_q, ctrl_q, src_q, dst_q, cw_q, next_q;
  logic [CNT_W-1:0] rem_q;
  logic             done_pend_q, err_pend_q, fault_q;

  // named internal events
  logic busy, ev_halt, ev_word, ev_ferr, ev_xdone, ev_xok, ev_xbad;
  logic ev_link, ev_end, hit_cmpl, hit_err;

  assign busy     = (state_q != S_IDLE);
  assign ev_halt  = busy && !en;
  assign ev_word  = en && (state_q == S_FETCH) && mem_ack && !mem_err;
  assign ev_ferr  = en && (state_q == S_FETCH) && mem_ack && mem_err;
  assign ev_xdone = en && (state_q == S_XWAIT) && xfer_done;
  assign ev_xok   = ev_xdone && !xfer_err;
  assign ev_xbad  = ev_xdone && xfer_err;
  assign ev_link  = ev_xok && cw_q[CW_LINK];
  assign ev_end   = ev_xok && !cw_q[CW_LINK];
  assign hit_cmpl = ev_xok && cmpl_armed(ctrl_q, cw_q, xfer_eot);
  assign hit_err  = ev_xbad && err_armed(ctrl_q, cw_q);
  assign finish   = ev_end || ev_ferr || ev_xbad;

  // walk sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= F_CTRL;
    end else if (ev_halt) begin
      state_q <= S_IDLE;
    end else begin
      case (state_q)
        S_IDLE: if (en) begin
          state_q <= S_FETCH;
          idx_q   <= F_CTRL;
        end
        S_FETCH: begin
          if (ev_ferr) state_q <= S_IDLE;
          else if (ev_word) begin
            if (idx_q == F_NEXT) state_q <= S_XSTART;
            else                 idx_q   <= fetch_idx_t'(idx_q + 3'd1);
          end
        end
        S_XSTART: state_q <= S_XWAIT;
        S_XWAIT: begin
          if (ev_link) begin
            state_q <= S_FETCH;
            idx_q   <= F_CTRL;
          end else if (ev_end || ev_xbad) begin
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // descriptor fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cw_q   <= '0;
      next_q <= '0;
      rem_q  <= '0;
    end else begin
      if (ev_word) begin
        case (idx_q)
          F_CTRL: ctrl_q <= mem_rdata;
          F_SRC:  src_q  <= mem_rdata;
          F_DST:  dst_q  <= mem_rdata;
          F_CNT: begin
            cw_q  <= mem_rdata;
            rem_q <= mem_rdata[CNT_W-1:0];
          end
          F_NEXT: next_q <= mem_rdata;
          default: ;
        endcase
      end
      if (ev_xok) rem_q <= '0;
    end
  end

  // descriptor address: software while idle, link while walking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                desc_q <= '0;
    else if (ev_link)                          desc_q <= next_q;
    else if (we_desc && (state_q == S_IDLE))   desc_q <= wdata;
  end

  // sticky status, write 1 to clear, set wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_pend_q <= 1'b0;
      err_pend_q  <= 1'b0;
      fault_q     <= 1'b0;
    end else begin
      if (hit_cmpl)                 done_pend_q <= 1'b1;
      else if (we_stat && wdata[0]) done_pend_q <= 1'b0;
      if (hit_err)                  err_pend_q  <= 1'b1;
      else if (we_stat && wdata[1]) err_pend_q  <= 1'b0;
      if (ev_ferr || ev_xbad)       fault_q     <= 1'b1;
      else if (we_stat && wdata[2]) fault_q     <= 1'b0;
    end
  end

  assign mem_req    = en && (state_q == S_FETCH);
  assign mem_addr   = field_addr(desc_q, idx_q);
  assign xfer_start = en && (state_q == S_XSTART);
  assign xfer_src   = src_q;
  assign xfer_dst   = dst_q;
  assign xfer_bytes = BW'(units_to_bytes(32'(rem_q), ctrl_q[1:0]));
  assign irq        = done_pend_q || err_pend_q;

  assign ctrl_o = ctrl_q;
  assign desc_o = desc_q;
  assign cnt_o  = {cw_q[31:CNT_W], rem_q};
  assign stat_o = {28'b0, busy, fault_q, err_pend_q, done_pend_q};

  // R3: a transfer begins only right after the last descriptor word arrived
  p_start_after_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_start) |-> $past(mem_ack));
  // R5: the start strobe lasts one cycle
  p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
  // R6: a finished chain drops its run bit
  p_end_clears_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end |=> !en);
  // R7: completion status needs the channel interrupt enable
  p_cmpl_needs_ie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_pend_q) |-> $past(ctrl_q[CTL_IE]));
  // R8: an aborted chain drops its run bit
  p_abort_clears_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_xbad || ev_ferr) |=> !en);
  // R11: halting reaches idle in one cycle
  p_halt_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_halt |=> !busy);
  // R12: while walking, only a link moves the descriptor address
  p_desc_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ev_link) |=> $stable(desc_q));
  // R13: a good transfer leaves no remaining units
  p_rem_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xok |=> (rem_q == '0));

endmodule

// File: rtl/sgd_walker.sv
module sgd_walker
  import sgd_pkg::*;
#(
  parameter int NCH   = 2,   // 1..8 channels
  parameter int CNT_W = 16   // unit count width, at most 24 (flags live above)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [6:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic [NCH-1:0]         mem_req,
  output logic [32*NCH-1:0]      mem_addr,
  input  logic [NCH-1:0]         mem_ack,
  input  logic [32*NCH-1:0]      mem_rdata,
  input  logic [NCH-1:0]         mem_err,
  output logic [NCH-1:0]         xfer_start,
  output logic [32*NCH-1:0]      xfer_src,
  output logic [32*NCH-1:0]      xfer_dst,
  output logic [(CNT_W+3)*NCH-1:0] xfer_bytes,
  input  logic [NCH-1:0]         xfer_done,
  input  logic [NCH-1:0]         xfer_eot,
  input  logic [NCH-1:0]         xfer_err,
  output logic [NCH-1:0]         irq
);

  localparam int BW = CNT_W + 3;

  logic [2:0]     ch_sel, off;
  logic           cmd_hit, ch_hit;
  logic [NCH-1:0] run, finish;
  logic [31:0]    ctrl_a [NCH];
  logic [31:0]    desc_a [NCH];
  logic [31:0]    cnt_a  [NCH];
  logic [31:0]    stat_a [NCH];

  assign ch_sel  = reg_addr[5:3];
  assign off     = reg_addr[2:0];
  assign cmd_hit = (reg_addr == CMD_ADDR);
  assign ch_hit  = !reg_addr[6] && (int'(ch_sel) < NCH);

  sgd_cmd #(.NCH(NCH)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we && cmd_hit),
    .wr_run  (reg_wdata[NCH-1:0]),
    .wr_mask (reg_wdata[CMD_MASK_LSB +: NCH]),
    .finish  (finish),
    .run     (run)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel = reg_we && ch_hit && (ch_sel == 3'(c));

    sgd_chan #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (run[c]),
      .we_desc    (sel && (off == OFF_DESC)),
      .we_stat    (sel && (off == OFF_STAT)),
      .wdata      (reg_wdata),
      .ctrl_o     (ctrl_a[c]),
      .desc_o     (desc_a[c]),
      .cnt_o      (cnt_a[c]),
      .stat_o     (stat_a[c]),
      .finish     (finish[c]),
      .mem_req    (mem_req[c]),
      .mem_addr   (mem_addr[c*32 +: 32]),
      .mem_ack    (mem_ack[c]),
      .mem_rdata  (mem_rdata[c*32 +: 32]),
      .mem_err    (mem_err[c]),
      .xfer_start (xfer_start[c]),
      .xfer_src   (xfer_src[c*32 +: 32]),
      .xfer_dst   (xfer_dst[c*32 +: 32]),
      .xfer_bytes (xfer_bytes[c*BW +: BW]),
      .xfer_done  (xfer_done[c]),
      .xfer_eot   (xfer_eot[c]),
      .xfer_err   (xfer_err[c]),
      .irq        (irq[c])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (cmd_hit) begin
      reg_rdata = 32'(run);
    end else if (ch_hit) begin
      for (int c = 0; c < NCH; c++) begin
        if (ch_sel == 3'(c)) begin
          case (off)
            OFF_CTRL: reg_rdata = ctrl_a[c];
            OFF_DESC: reg_rdata = desc_a[c];
            OFF_CNT:  reg_rdata = cnt_a[c];
            OFF_STAT: reg_rdata = stat_a[c];
            default:  reg_rdata = '0;
          endcase
        end
      end
    end
  end

endmodule

// File: tb/tb_sgd_walker.sv
`timescale 1ns/1ps
module tb_sgd_walker;

  localparam int NCH = 2;
  localparam int CNT_W = 16;
  localparam int BW = CNT_W + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] mem_req, xfer_start, irq;
  logic [32*NCH-1:0] mem_addr, xfer_src, xfer_dst;
  logic [BW*NCH-1:0] xfer_bytes;
  logic [NCH-1:0] mem_ack = '0, mem_err = '0;
  logic [32*NCH-1:0] mem_rdata = '0;
  logic [NCH-1:0] xfer_done = '0, xfer_eot = '0, xfer_err = '0;

  always #10 clk = ~clk;

  sgd_walker #(.NCH(NCH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_err(mem_err), .xfer_start(xfer_start), .xfer_src(xfer_src),
    .xfer_dst(xfer_dst), .xfer_bytes(xfer_bytes), .xfer_done(xfer_done),
    .xfer_eot(xfer_eot), .xfer_err(xfer_err), .irq(irq)
  );

  // memory and data-mover models
  logic [31:0] mem [0:255];
  logic [31:0] fetch_err_addr = 32'hFFFF_FFFF;
  logic x_eot = 1'b0, x_hang = 1'b0;
  int x_err_at = -1;
  int nst [0:1] = '{0, 0};
  int cd  [0:1] = '{0, 0};
  logic [31:0] lsrc [0:1][0:63];
  logic [31:0] ldst [0:1][0:63];
  logic [31:0] lbyt [0:1][0:63];
  logic        lirq [0:1][0:63];
  logic [31:0] faddr [0:255];
  int nf = 0;

  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (mem_ack[c]) begin
        mem_ack[c] = 1'b0;
        mem_err[c] = 1'b0;
      end else if (mem_req[c]) begin
        mem_ack[c] = 1'b1;
        mem_rdata[c*32 +: 32] = mem[mem_addr[c*32+2 +: 8]];
        mem_err[c] = (mem_addr[c*32 +: 32] == fetch_err_addr);
        if (c == 0 && nf < 256) begin
          faddr[nf] = mem_addr[31:0];
          nf = nf + 1;
        end
      end
      xfer_done[c] = 1'b0;
      xfer_eot[c]  = 1'b0;
      xfer_err[c]  = 1'b0;
      if (xfer_start[c]) begin
        if (nst[c] < 64) begin
          lsrc[c][nst[c]] = xfer_src[c*32 +: 32];
          ldst[c][nst[c]] = xfer_dst[c*32 +: 32];
          lbyt[c][nst[c]] = 32'(xfer_bytes[c*BW +: BW]);
          lirq[c][nst[c]] = irq[c];
        end
        nst[c] = nst[c] + 1;
        cd[c] = 3;
      end else if (cd[c] > 0) begin
        cd[c] = cd[c] - 1;
        if (cd[c] == 0 && !x_hang) begin
          xfer_done[c] = 1'b1;
          xfer_eot[c]  = x_eot;
          xfer_err[c]  = (x_err_at >= 0) && (nst[c] - 1 == x_err_at);
        end
      end
    end
  end

  int checks = 0, fails = 0;
  logic [31:0] e_addr [0:7];
  logic [31:0] e_ctrl [0:7];
  logic [31:0] e_src  [0:7];
  logic [31:0] e_dst  [0:7];
  logic [31:0] e_unit [0:7];
  logic [31:0] e_cw   [0:7];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic build(input int base, input int L, input int w,
                       input logic ie, input logic [31:0] lastflags);
    for (int i = 0; i < L; i++) begin
      int a;
      a = base + i * 32;
      e_addr[i] = 32'(a);
      e_ctrl[i] = ({31'b0, ie} << 31) | 32'(i << 8) | 32'(L << 12) | 32'(w);
      e_src[i]  = 32'(32'h1000 * (i + 1) + w * 32'h100 + L);
      e_dst[i]  = 32'(32'h8000 + i * 32'h40 + w);
      e_unit[i] = 32'(1 + i + 2 * w + L);
      e_cw[i]   = e_unit[i] | 32'h0A00_0000 | 32'h1000_0000 |
                  ((i < L - 1) ? 32'h8000_0000 : lastflags);
      mem[(a >> 2) + 0] = e_ctrl[i];
      mem[(a >> 2) + 1] = e_src[i];
      mem[(a >> 2) + 2] = e_dst[i];
      mem[(a >> 2) + 3] = e_cw[i];
      mem[(a >> 2) + 4] = (i < L - 1) ? 32'(base + (i + 1) * 32) : 32'h0;
    end
  endtask

  task automatic start_wait(input int c, input logic [31:0] dptr);
    logic [31:0] v;
    wr(7'(c * 8 + 1), dptr);
    wr(7'h40, (32'h1 << (16 + c)) | (32'h1 << c));
    for (int k = 0; k < 2000; k++) begin
      rd(7'h40, v);
      if (!v[c]) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  // normal chain on channel 0, then all result checks
  task automatic sweep_run(input int L, input int w);
    int s0, f0;
    logic [31:0] v;
    build(32'h40, L, w, 1'b1, 32'h4000_0000);
    s0 = nst[0]; f0 = nf;
    start_wait(0, e_addr[0]);
    chk("R6 descriptors walked", 32'(nst[0] - s0), 32'(L));
    chk("R3 words fetched", 32'(nf - f0), 32'(5 * L));
    for (int j = 0; j < 5 * L && f0 + j < 256; j++)
      chk("R3 fetch address", faddr[f0 + j], e_addr[j / 5] + 32'(4 * (j % 5)));
    for (int i = 0; i < L; i++) begin
      chk("R5 source", lsrc[0][s0 + i], e_src[i]);
      chk("R5 destination", ldst[0][s0 + i], e_dst[i]);
      chk("R5 byte count", lbyt[0][s0 + i], e_unit[i] << w);
      chk("R7 no irq before last", {31'b0, lirq[0][s0 + i]}, 32'h0);
    end
    rd(7'h00, v); chk("R4 control copied", v, e_ctrl[L - 1]);
    rd(7'h01, v); chk("R6 last descriptor address", v, e_addr[L - 1]);
    rd(7'h02, v); chk("R13 count after done", v, e_cw[L - 1] & 32'hFFFF_0000);
    rd(7'h03, v); chk("R10 status done", v, 32'h1);
    rd(7'h40, v); chk("R6 run cleared", v, 32'h0);
    chk("R10 irq set", {31'b0, irq[0]}, 32'h1);
    wr(7'h03, 32'h7);
    @(negedge clk);
    chk("R10 irq cleared by W1C", {31'b0, irq[0]}, 32'h0);
  endtask

  task automatic single(input logic ie, input logic [31:0] fl, input logic eot,
                        input logic [31:0] exp_stat, input string tag);
    logic [31:0] v;
    build(32'h40, 1, 2, ie, fl);
    x_eot = eot;
    start_wait(0, e_addr[0]);
    x_eot = 1'b0;
    rd(7'h03, v); chk(tag, v, exp_stat);
    wr(7'h03, 32'h7);
  endtask

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int s0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < NCH; c++)
      for (int o = 0; o < 4; o++) begin
        rd(7'(c * 8 + o), v); chk("R1 reset register", v, 32'h0);
      end
    rd(7'h40, v); chk("R1 reset command", v, 32'h0);
    chk("R1 reset outputs", {26'b0, mem_req, xfer_start, irq}, 32'h0);

    // R2 write without mask is ignored
    wr(7'h40, 32'h0000_0003);
    rd(7'h40, v); chk("R2 unmasked write ignored", v, 32'h0);
    repeat (5) @(negedge clk);
    chk("R2 no fetch after unmasked write", {30'b0, mem_req}, 32'h0);

    // near-exhaustive sweep: width code x chain length
    for (int w = 0; w < 4; w++)
      for (int L = 1; L <= 3; L++)
        sweep_run(L, w);

    // R7 completion flag selection
    single(1'b1, 32'h2000_0000, 1'b1, 32'h1, "R7 early-end flag with early end");
    single(1'b1, 32'h4000_0000, 1'b1, 32'h0, "R7 terminal flag with early end");
    single(1'b1, 32'h2000_0000, 1'b0, 32'h0, "R7 early-end flag with terminal count");
    single(1'b0, 32'h4000_0000, 1'b0, 32'h0, "R7 channel enable off");

    // R8 transfer error mid-chain
    build(32'h40, 3, 1, 1'b1, 32'h4000_0000);
    s0 = nst[0];
    x_err_at = s0 + 1;
    start_wait(0, e_addr[0]);
    x_err_at = -1;
    chk("R8 walk stopped", 32'(nst[0] - s0), 32'h2);
    rd(7'h03, v); chk("R8 fault and error pending", v, 32'h6);
    rd(7'h01, v); chk("R8 residue descriptor", v, e_addr[1]);
    rd(7'h02, v); chk("R8 residue count", v, e_cw[1]);
    rd(7'h40, v); chk("R8 run cleared", v, 32'h0);
    chk("R8 irq", {31'b0, irq[0]}, 32'h1);
    wr(7'h03, 32'h7);

    // R9 fetch error
    build(32'h40, 3, 0, 1'b1, 32'h4000_0000);
    s0 = nst[0];
    fetch_err_addr = e_addr[1] + 32'd8;
    start_wait(0, e_addr[0]);
    fetch_err_addr = 32'hFFFF_FFFF;
    chk("R9 walk stopped", 32'(nst[0] - s0), 32'h1);
    rd(7'h03, v); chk("R9 fault only", v, 32'h4);
    rd(7'h01, v); chk("R9 failing descriptor", v, e_addr[1]);
    rd(7'h40, v); chk("R9 run cleared", v, 32'h0);
    chk("R9 no irq", {31'b0, irq[0]}, 32'h0);
    wr(7'h03, 32'h7);

    // R11 / R12 halt during a transfer
    build(32'h40, 2, 3, 1'b1, 32'h4000_0000);
    s0 = nst[0];
    x_hang = 1'b1;
    wr(7'h01, e_addr[0]);
    wr(7'h40, 32'h0001_0001);
    for (int k = 0; k < 200 && nst[0] == s0; k++) @(negedge clk);
    wr(7'h01, 32'h300);
    rd(7'h01, v); chk("R12 write ignored while busy", v, e_addr[0]);
    rd(7'h03, v); chk("R10 busy bit", v, 32'h8);
    wr(7'h40, 32'h0001_0000);
    @(negedge clk);
    rd(7'h03, v); chk("R11 idle after halt", v, 32'h0);
    rd(7'h02, v); chk("R11 count kept", v, e_cw[0]);
    repeat (30) @(negedge clk);
    chk("R11 no further transfer", 32'(nst[0] - s0), 32'h1);
    x_hang = 1'b0;
    wr(7'h01, 32'h300);
    rd(7'h01, v); chk("R12 write taken while idle", v, 32'h300);

    // R14 channel 1 independent
    build(32'h200, 2, 1, 1'b1, 32'h4000_0000);
    s0 = nst[1];
    start_wait(1, e_addr[0]);
    chk("R14 channel 1 walked", 32'(nst[1] - s0), 32'h2);
    chk("R14 channel 1 bytes", lbyt[1][s0 + 1], e_unit[1] << 1);
    rd(7'h0B, v); chk("R14 channel 1 status", v, 32'h1);
    rd(7'h09, v); chk("R14 channel 1 descriptor", v, e_addr[1]);
    rd(7'h03, v); chk("R14 channel 0 untouched", v, 32'h0);
    chk("R14 irq vector", {30'b0, irq}, 32'h2);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule